// File: doc/BRIEF.md
# Masked Cache Write Unit

This unit sits between a processor data port and video memory. When the processor writes a byte, the unit either passes it on as one ordinary memory write, or expands it into a burst of four byte writes. The data for the burst comes from a 32-bit cache word, from a signed multiply-accumulate result, or from one cache byte repeated into all four lanes. Each of the four bytes carries a 2-bit nibble mask. A set mask bit suppresses the write of that nibble. Mask bit 1 covers data bits [7:4] and mask bit 0 covers data bits [3:0].

The masks come from the processor byte itself. In the transparent mode they are instead derived from the data, so that zero pixels leave memory untouched. This applies at nibble granularity in 4-bit pixel mode and at byte granularity in 8-bit pixel mode.

The unit captures everything it needs on the cycle it accepts the write. It then issues the beats one per cycle through a valid/ready memory port. A busy flag tells the processor side that further writes are ignored until the last beat has been accepted.

Top module: `vcw_cache_writer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `mem_valid` and `busy` are 0, even if a burst was in progress when reset arrived.
- R2: A cache-mode write issues exactly four beats. Their addresses are the processor address with its two low bits cleared, plus 0, 1, 2 and 3, in that order.
- R3: With the multiplier on, `cache_word[15:0]` and `cache_word[31:16]` are multiplied as signed 16-bit values. The product is added to `accum`, or subtracted from it when `cfg_sub` is 1. Bits [8k+7:8k] of the 32-bit result form the data of beat k.
- R4: With the multiplier and byte cycling off, beat k carries `cache_word[8k+7:8k]`.
- R5: With byte cycling on, every beat carries `cache_word[8s+7:8s]`, where s is `cfg_byte_sel`. The multiplier flag and the other cache bytes then have no effect.
- R6: Without transparency in cache mode, beat k carries mask `cpu_data[2k+1:2k]`.
- R7: With transparency in 4-bit mode, mask bit 1 of a beat is 1 exactly when data bits [7:4] are zero. Mask bit 0 is 1 exactly when data bits [3:0] are zero. `cpu_data` is ignored for masks.
- R8: With transparency in 8-bit mode, the mask of a beat is 2'b11 when its data byte is zero and 2'b00 otherwise.
- R9: With cache mode off, a single beat is issued to the unaligned processor address with mask 2'b00, whatever the transparency flags. Its data is the selected cache byte when byte cycling is on and `cpu_data` otherwise.
- R10: A write accepted while `busy` is 0 raises `mem_valid` on the next cycle. While `busy` is 1, `cpu_wr` is ignored. `busy` and `mem_valid` fall on the cycle after the last beat is accepted.
- R11: While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr`, `mem_data` and `mem_mask` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Processor write strobe, taken when busy is 0 |
| cpu_data | input | 8 | Processor write byte (data or masks) |
| cpu_addr | input | 17 | Target memory address |
| cfg_cache_wr | input | 1 | Four-beat cache write mode |
| cfg_cycle | input | 1 | Replicate the selected cache byte |
| cfg_mult | input | 1 | Use the multiply-accumulate result |
| cfg_sub | input | 1 | Subtract the product instead of adding |
| cfg_trans | input | 1 | Derive masks from zero data |
| cfg_nib4 | input | 1 | 4-bit pixel mode for transparency |
| cfg_byte_sel | input | 2 | Cache byte index |
| cache_word | input | 32 | Cache contents, byte 0 in bits [7:0] |
| accum | input | 32 | Accumulator value |
| busy | output | 1 | Burst in progress, processor writes ignored |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 17 | Beat address |
| mem_data | output | 8 | Beat data |
| mem_mask | output | 2 | Nibble suppress mask, bit 1 = bits [7:4] |

## Verification
The four-beat path is driven with plain cache bytes, with additive and subtractive products that change sign, with byte cycling while the multiplier flag is also raised, and with transparency on a multiplier result. Together these separate the three data sources and show that cycling takes priority. The mask patterns use mixed zero and nonzero nibbles, so that 4-bit, 8-bit and processor-supplied masks each give a different answer for the same bytes. The single-beat path is tried with an unaligned address and with transparency raised, which tells the ordinary path apart from the burst path. Back-pressure, writes arriving while busy, and reset during a burst check the sequencing.

// File: rtl/vcw_pkg.sv
package vcw_pkg;

    // mode flags captured with each processor write
    typedef struct packed {
        logic cache_wr;
        logic cycle;
        logic mult;
        logic sub;
        logic trans;
        logic nib4;
    } wr_mode_t;

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } phase_e;

endpackage

// File: rtl/vcw_mac.sv
// Signed half-word multiply with accumulate or deduct.
module vcw_mac #(
    parameter int HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] operands,
    input  logic [2*HALF_W-1:0] acc,
    input  logic                sub,
    output logic [2*HALF_W-1:0] result
);
    localparam int FULL_W = 2 * HALF_W;

    logic [FULL_W-1:0] lo_ext;
    logic [FULL_W-1:0] hi_ext;
    logic [FULL_W-1:0] prod;

    // sign extension keeps the low FULL_W bits of the product exact
    assign lo_ext = {{HALF_W{operands[HALF_W-1]}}, operands[HALF_W-1:0]};
    assign hi_ext = {{HALF_W{operands[FULL_W-1]}}, operands[FULL_W-1:HALF_W]};
    assign prod   = lo_ext * hi_ext;
    assign result = sub ? (acc - prod) : (acc + prod);

endmodule

// File: rtl/vcw_lane_mask.sv
// Nibble suppress mask for one byte lane.
module vcw_lane_mask #(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] data,
    input  logic [1:0]        cpu_bits,
    input  logic              trans,
    input  logic              nib4,
    output logic [1:0]        mask
);
    localparam int NIB_W = LANE_W / 2;

    logic hi_zero;
    logic lo_zero;

    assign hi_zero = (data[LANE_W-1:NIB_W] == '0);
    assign lo_zero = (data[NIB_W-1:0] == '0);

    always_comb begin
        if (!trans)
            mask = cpu_bits;
        else if (nib4)
            mask = {hi_zero, lo_zero};
        else
            mask = {2{hi_zero & lo_zero}};
    end

endmodule

// File: rtl/vcw_beat_former.sv
// Builds lane data and masks for a burst, plus the single-beat byte.
module vcw_beat_former #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  vcw_pkg::wr_mode_t              mode,
    input  logic [$clog2(LANES)-1:0]       byte_sel,
    input  logic [LANE_W-1:0]              cpu_data,
    input  logic [LANES*LANE_W-1:0]        cache_word,
    input  logic [LANES*LANE_W-1:0]        accum,
    output logic [LANES-1:0][LANE_W-1:0]   lane_data,
    output logic [LANES-1:0][1:0]          lane_mask,
    output logic [LANE_W-1:0]              single_data
);
    localparam int WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] mac_word;
    logic [LANE_W-1:0] sel_byte;

    vcw_mac #(.HALF_W(WORD_W / 2)) u_mac (
        .operands (cache_word),
        .acc      (accum),
        .sub      (mode.sub),
        .result   (mac_word)
    );

    assign sel_byte    = cache_word[byte_sel*LANE_W +: LANE_W];
    assign single_data = mode.cycle ? sel_byte : cpu_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // cycling outranks the multiplier, which outranks the raw cache
        assign lane_data[g] = mode.cycle ? sel_byte
                            : mode.mult  ? mac_word[g*LANE_W +: LANE_W]
                            :              cache_word[g*LANE_W +: LANE_W];

        vcw_lane_mask #(.LANE_W(LANE_W)) u_mask (
            .data     (lane_data[g]),
            .cpu_bits (cpu_data[2*g +: 2]),
            .trans    (mode.trans),
            .nib4     (mode.nib4),
            .mask     (lane_mask[g])
        );
    end

endmodule

// File: rtl/vcw_cache_writer.sv
// Top: accepts processor writes and streams masked beats to memory.
module vcw_cache_writer #(
    parameter int ADDR_W = 17,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_wr,
    input  logic [LANE_W-1:0]          cpu_data,
    input  logic [ADDR_W-1:0]          cpu_addr,
    input  logic                       cfg_cache_wr,
    input  logic                       cfg_cycle,
    input  logic                       cfg_mult,
    input  logic                       cfg_sub,
    input  logic                       cfg_trans,
    input  logic                       cfg_nib4,
    input  logic [$clog2(LANES)-1:0]   cfg_byte_sel,
    input  logic [LANES*LANE_W-1:0]    cache_word,
    input  logic [LANES*LANE_W-1:0]    accum,
    output logic                       busy,
    output logic                       mem_valid,
    input  logic                       mem_ready,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [LANE_W-1:0]          mem_data,
    output logic [1:0]                 mem_mask
);
    import vcw_pkg::*;

    localparam int SEL_W = $clog2(LANES);
    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(LANES - 1);

    typedef struct packed {
        phase_e                       phase;
        logic [ADDR_W-1:0]            addr;
        logic [LANES-1:0][LANE_W-1:0] data;
        logic [LANES-1:0][1:0]        mask;
        logic [SEL_W-1:0]             idx;
        logic                         multi;
        logic                         cyc;
    } seq_t;

    wr_mode_t                     mode;
    logic [LANES-1:0][LANE_W-1:0] lane_data;
    logic [LANES-1:0][1:0]        lane_mask;
    logic [LANE_W-1:0]            single_data;
    seq_t                         cur_q;
    seq_t                         nxt_d;
    logic                         seq_multi;
    logic                         seq_cyc;

    assign mode = '{cache_wr: cfg_cache_wr, cycle: cfg_cycle, mult: cfg_mult,
                    sub: cfg_sub, trans: cfg_trans, nib4: cfg_nib4};

    vcw_beat_former #(.LANES(LANES), .LANE_W(LANE_W)) u_former (
        .mode        (mode),
        .byte_sel    (cfg_byte_sel),
        .cpu_data    (cpu_data),
        .cache_word  (cache_word),
        .accum       (accum),
        .lane_data   (lane_data),
        .lane_mask   (lane_mask),
        .single_data (single_data)
    );

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.phase)
            PH_IDLE: begin
                if (cpu_wr) begin
                    nxt_d.phase = PH_SEND;
                    nxt_d.idx   = '0;
                    nxt_d.multi = cfg_cache_wr;
                    nxt_d.cyc   = cfg_cycle;
                    if (cfg_cache_wr) begin
                        nxt_d.addr = {cpu_addr[ADDR_W-1:SEL_W], {SEL_W{1'b0}}};
                        nxt_d.data = lane_data;
                        nxt_d.mask = lane_mask;
                    end else begin
                        nxt_d.addr    = cpu_addr;
                        nxt_d.data    = '0;
                        nxt_d.mask    = '0;
                        nxt_d.data[0] = single_data;
                    end
                end
            end
            PH_SEND: begin
                if (mem_ready) begin
                    if (!cur_q.multi || cur_q.idx == LAST_IDX) begin
                        nxt_d.phase = PH_IDLE;
                    end else begin
                        nxt_d.idx  = cur_q.idx + 1'b1;
                        nxt_d.addr = cur_q.addr + 1'b1;
                    end
                end
            end
            default: nxt_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy      = (cur_q.phase == PH_SEND);
    assign mem_valid = (cur_q.phase == PH_SEND);
    assign mem_addr  = cur_q.addr;
    assign mem_data  = cur_q.data[cur_q.idx];
    assign mem_mask  = cur_q.mask[cur_q.idx];
    assign seq_multi = cur_q.multi;
    assign seq_cyc   = cur_q.cyc;

endmodule

// File: rtl/vcw_cache_writer_chk.sv
// Protocol checker for vcw_cache_writer.
module vcw_cache_writer_chk #(
    parameter int ADDR_W = 17,
    parameter int SEL_W  = 2,
    parameter int LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic              busy,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANE_W-1:0] mem_data,
    input logic [1:0]        mem_mask,
    input logic              multi,
    input logic              cyc
);

    AST_ALIGNED_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_valid) && multi) |-> (mem_addr[SEL_W-1:0] == '0)); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && multi && (mem_addr[SEL_W-1:0] != '1))
        |=> (mem_valid && (mem_addr == $past(mem_addr) + 1'b1))); // R2

    AST_CYCLE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && multi && cyc && (mem_addr[SEL_W-1:0] != '1))
        |=> (mem_data == $past(mem_data))); // R5

    AST_ORD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !multi) |-> (mem_mask == 2'b00)); // R9

    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !busy) |=> mem_valid); // R10

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready)
        |=> (mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_mask))); // R11

endmodule

bind vcw_cache_writer vcw_cache_writer_chk #(
    .ADDR_W (ADDR_W),
    .SEL_W  ($clog2(LANES)),
    .LANE_W (LANE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .busy      (busy),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_mask  (mem_mask),
    .multi     (seq_multi),
    .cyc       (seq_cyc)
);

// File: tb/vcw_cache_writer_test.sv
module vcw_cache_writer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_data = '0;
    logic [16:0] cpu_addr = '0;
    logic        cfg_cache_wr = 1'b0, cfg_cycle = 1'b0, cfg_mult = 1'b0;
    logic        cfg_sub = 1'b0, cfg_trans = 1'b0, cfg_nib4 = 1'b0;
    logic [1:0]  cfg_byte_sel = '0;
    logic [31:0] cache_word = '0;
    logic [31:0] accum = '0;
    logic        busy, mem_valid;
    logic        mem_ready = 1'b1;
    logic [16:0] mem_addr;
    logic [7:0]  mem_data;
    logic [1:0]  mem_mask;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    vcw_cache_writer uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_data(cpu_data),
        .cpu_addr(cpu_addr), .cfg_cache_wr(cfg_cache_wr), .cfg_cycle(cfg_cycle),
        .cfg_mult(cfg_mult), .cfg_sub(cfg_sub), .cfg_trans(cfg_trans),
        .cfg_nib4(cfg_nib4), .cfg_byte_sel(cfg_byte_sel), .cache_word(cache_word),
        .accum(accum), .busy(busy), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_mask(mem_mask)
    );

    typedef struct packed {
        logic        cw, cyc, mul, sub, tr, n4;
        logic [1:0]  sel;
        logic [7:0]  cpu;
        logic [16:0] addr;
        logic [31:0] cache;
        logic [31:0] acc;
        logic [2:0]  nbeats;
        logic        stall;
    } vec_t;

    localparam int NVEC = 10;
    // cw cyc mul sub tr n4 sel cpu addr cache acc nbeats stall
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'hE4,17'h12347,32'hDDCCBBAA,32'h0,3'd4,1'b0},
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,2'd0,8'h00,17'h00100,32'h0003FFFE,32'd100,3'd4,1'b0},
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,8'h1B,17'h00202,32'h7FFF7FFF,32'h0,3'd4,1'b0},
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,2'd2,8'h00,17'h00305,32'h44332211,32'h55,3'd4,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,8'hFF,17'h00400,32'h001000FF,32'h0,3'd4,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,8'h00,17'h00501,32'h0FF00012,32'h0,3'd4,1'b0},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,8'h00,17'h00013,32'h12345678,32'h0,3'd1,1'b0},
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,8'h11,17'h1FFFF,32'hBE000000,32'h0,3'd1,1'b0},
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,2'd0,8'hFF,17'h00600,32'h00010010,32'h0,3'd4,1'b0},
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,8'h1B,17'h0070A,32'hCAFEF00D,32'h0,3'd4,1'b1}
    };

    logic [16:0] exp_addr [4];
    logic [7:0]  exp_data [4];
    logic [1:0]  exp_mask [4];
    int          exp_n;
    logic [16:0] got_addr [8];
    logic [7:0]  got_data [8];
    logic [1:0]  got_mask [8];
    int          got_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected beats from the requirements
    task automatic build_expect(input vec_t v);
        logic [31:0] word;
        int p;
        if (!v.cw) begin
            exp_n       = 1;
            exp_addr[0] = v.addr;
            exp_data[0] = v.cyc ? v.cache[v.sel*8 +: 8] : v.cpu;
            exp_mask[0] = 2'b00;
        end else begin
            exp_n = 4;
            p = int'($signed(v.cache[15:0])) * int'($signed(v.cache[31:16]));
            if (v.cyc)      word = {4{v.cache[v.sel*8 +: 8]}};
            else if (v.mul) word = v.sub ? (v.acc - p) : (v.acc + p);
            else            word = v.cache;
            for (int k = 0; k < 4; k++) begin
                exp_addr[k] = {v.addr[16:2], 2'(k)};
                exp_data[k] = word[k*8 +: 8];
                if (!v.tr)      exp_mask[k] = v.cpu[2*k +: 2];
                else if (v.n4)  exp_mask[k] = {exp_data[k][7:4] == 4'h0, exp_data[k][3:0] == 4'h0};
                else            exp_mask[k] = {2{exp_data[k] == 8'h00}};
            end
        end
    endtask

    task automatic drive(input vec_t v);
        cpu_data = v.cpu; cpu_addr = v.addr; cfg_cache_wr = v.cw;
        cfg_cycle = v.cyc; cfg_mult = v.mul; cfg_sub = v.sub;
        cfg_trans = v.tr; cfg_nib4 = v.n4; cfg_byte_sel = v.sel;
        cache_word = v.cache; accum = v.acc;
    endtask

    // collect handshaken beats; checks hold under back-pressure (R11)
    task automatic collect(input int n, input bit stall);
        logic        held = 1'b0;
        logic [16:0] pa = '0;
        logic [7:0]  pd = '0;
        logic [1:0]  pm = '0;
        got_n = 0;
        for (int c = 0; c < 40 && got_n < n; c++) begin
            @(negedge clk);
            cpu_wr    = 1'b0;
            mem_ready = stall ? c[0] : 1'b1;
            #1;
            if (held)
                chk(mem_addr == pa && mem_data == pd && mem_mask == pm, "R11",
                    "beat held", {5'd0, mem_addr, mem_data, mem_mask}, {5'd0, pa, pd, pm});
            held = mem_valid && !mem_ready;
            pa = mem_addr; pd = mem_data; pm = mem_mask;
            if (mem_valid && mem_ready) begin
                got_addr[got_n] = mem_addr;
                got_data[got_n] = mem_data;
                got_mask[got_n] = mem_mask;
                got_n++;
            end
        end
        mem_ready = 1'b1;
        @(negedge clk); #1;
        chk(!mem_valid && !busy, "R10", "idle after last beat",
            {30'd0, mem_valid, busy}, 32'd0);
    endtask

    task automatic compare(input vec_t v, input int vi);
        string dtag, mtag, atag;
        atag = v.cw ? "R2" : "R9";
        dtag = !v.cw ? "R9" : v.cyc ? "R5" : v.mul ? "R3" : "R4";
        mtag = !v.cw ? "R9" : !v.tr ? "R6" : v.n4 ? "R7" : "R8";
        chk(got_n == exp_n, atag, $sformatf("beat count vec%0d", vi), got_n, exp_n);
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            chk(got_addr[k] == exp_addr[k], atag, $sformatf("addr vec%0d beat%0d", vi, k),
                {15'd0, got_addr[k]}, {15'd0, exp_addr[k]});
            chk(got_data[k] == exp_data[k], dtag, $sformatf("data vec%0d beat%0d", vi, k),
                {24'd0, got_data[k]}, {24'd0, exp_data[k]});
            chk(got_mask[k] == exp_mask[k], mtag, $sformatf("mask vec%0d beat%0d", vi, k),
                {30'd0, got_mask[k]}, {30'd0, exp_mask[k]});
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        vec_t alt;
        repeat (3) @(negedge clk);
        #1;
        chk(!mem_valid && !busy, "R1", "in reset", {30'd0, mem_valid, busy}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!mem_valid && !busy, "R1", "after reset", {30'd0, mem_valid, busy}, 32'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            build_expect(VECS[i]);
            chk(exp_n == int'(VECS[i].nbeats), "R2", "table beat count", exp_n, VECS[i].nbeats);
            cpu_wr = 1'b1;
            collect(int'(VECS[i].nbeats), VECS[i].stall);
            compare(VECS[i], i);
        end

        // R10: writes arriving while busy are ignored
        @(negedge clk);
        drive(VECS[0]);
        build_expect(VECS[0]);
        cpu_wr = 1'b1;
        mem_ready = 1'b0;
        alt = VECS[4];
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            drive(alt);
            cpu_wr = 1'b1;
            #1;
            chk(busy, "R10", "busy during burst", {31'd0, busy}, 32'd1);
        end
        collect(4, 1'b0);
        compare(VECS[0], 100);
        repeat (3) begin
            @(negedge clk); #1;
            chk(!mem_valid, "R10", "no extra burst", {31'd0, mem_valid}, 32'd0);
        end

        // R1: reset in the middle of a burst
        @(negedge clk);
        drive(VECS[1]);
        cpu_wr = 1'b1;
        mem_ready = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
        #1;
        chk(mem_valid, "R10", "burst started", {31'd0, mem_valid}, 32'd1);
        rst_n = 1'b0;
        #1;
        chk(!mem_valid && !busy, "R1", "reset mid burst", {30'd0, mem_valid, busy}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        mem_ready = 1'b1;
        @(negedge clk); #1;
        chk(!mem_valid && !busy, "R1", "idle after mid reset", {30'd0, mem_valid, busy}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule